// File: doc/BRIEF.md
# Microengine Debug Breakpoint Unit

This unit sits beside a microsequencer and watches it for debug stop conditions. Six sources can stop it. The first is a match between the microprogram counter and a PC compare register. The second is a match between the channel register and a channel compare register. The other four are the host-service, link-service, match-recognition and transition-detect latches. Each source has its own enable bit. When an enabled source fires, the unit raises a halt request and a one-cycle breakpoint pulse. It also sets a sticky status word that records which kind of source caused the stop. A breakpoint acknowledge or a freeze input clears the whole status word at once. When nothing is set, the halt request drops.

Breakpoints are evaluated only at specific moments. The PC source and the four latch sources are evaluated only while the beginning-of-state strobe is high. The channel source is evaluated on that strobe and also on a microcode write of the channel register. The unit also holds the channel-condition capture latch. On each channel register write it always takes the new channel's pin state. It takes the new channel's match-recognition and transition-detect conditions only when the capture-mode bit is 1.

Software reaches the control, compare and status registers through a simple synchronous write / combinational read port.

Top module: `dbg_brk_unit`

## Requirements
- R1: After reset, halt_o and brk_o are 0, all status bits are 0, and the control and compare registers read 0.
- R2: If PC enable (control bit 0) is 1 and the strobe state_start_i is high in a cycle where pc_i equals the PC compare register, then in the next cycle halt_o is 1 and status bits 3 (main) and 2 (PC cause) are 1.
- R3: If channel enable (control bit 1) is 1 and chan_i equals the channel compare register in a cycle where state_start_i or chan_wr_i is high, then in the next cycle halt_o is 1 and status bits 3 and 1 (channel cause) are 1.
- R4: The host (control bit 2), link (bit 3), match-recognition (bit 4) and transition-detect (bit 5) sources fire only when their input is high and their enable is 1 in a cycle with state_start_i high. Any one of them sets status bit 3 and bit 0 (service cause).
- R5: halt_o equals the main flag and stays high while it is set. brk_o is high for exactly the one cycle after the main flag goes from 0 to 1.
- R6: ack_i or freeze_i high at a clock edge clears the main flag and all three cause bits together. This clear wins over a breakpoint that fires in the same cycle.
- R7: While the main flag is set and no clear arrives, newly firing sources leave the status word unchanged.
- R8: A source with its enable at 0, or an evaluation that is not gated by its strobe, does not raise halt_o.
- R9: On chan_wr_i, cond_pin_o takes new_pin_i. cond_mrec_o and cond_tdet_o take new_mrec_i and new_tdet_i only if capture mode (control bit 8) is 1; otherwise they keep their values. Without chan_wr_i, all three hold.
- R10: Register map on reg_addr_i: 0 is control (bits 5:0 enables, bit 8 capture mode), 1 is the PC compare register, 2 is the channel compare register, and 3 is status (bit 3 main, 2 PC, 1 channel, 0 service). Writes take effect at the next edge. Writes to address 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | DW | Write data |
| reg_rdata_o | output | DW | Read data of the addressed register |
| pc_i | input | PC_W | Microprogram counter |
| chan_i | input | CH_W | Current channel register value |
| chan_wr_i | input | 1 | Microcode writes the channel register |
| state_start_i | input | 1 | Beginning-of-state strobe |
| host_sr_i | input | 1 | Host service latch |
| link_sr_i | input | 1 | Link service latch |
| mrec_i | input | 1 | Match recognition latch |
| tdet_i | input | 1 | Transition detect latch |
| new_pin_i | input | 1 | Pin state of the newly selected channel |
| new_mrec_i | input | 1 | Match condition of the newly selected channel |
| new_tdet_i | input | 1 | Transition condition of the newly selected channel |
| ack_i | input | 1 | Breakpoint acknowledge |
| freeze_i | input | 1 | Freeze |
| halt_o | output | 1 | Halt request to the microsequencer |
| brk_o | output | 1 | One-cycle breakpoint pulse |
| cond_pin_o | output | 1 | Captured pin state |
| cond_mrec_o | output | 1 | Captured match condition |
| cond_tdet_o | output | 1 | Captured transition condition |

## Verification
The bench targets an acknowledge that lands in the same cycle as a new hit. A design that gives the hit priority would leave halt_o set when it should be clear. It also drives new hits while the flag is already set. A design that lets them through would add cause bits that were never part of the original stop, or would pulse brk_o again. Compare matches without the strobe, and latch inputs with the enable at 0, check for spurious halts. Channel writes in capture mode 0 show whether the match and transition conditions leak through. Constrained random traffic mixes all of these with register writes, including writes to the read-only status address.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_PCBP = 2'd1,
        A_CHBP = 2'd2,
        A_STAT = 2'd3
    } addr_e;

    localparam int EN_PC    = 0;
    localparam int EN_CH    = 1;
    localparam int EN_SVC0  = 2;   // host, link, mrec, tdet follow in order
    localparam int NUM_SVC  = 4;
    localparam int NUM_EN   = EN_SVC0 + NUM_SVC;
    localparam int MODE_BIT = 8;

    typedef struct packed {
        logic flag;
        logic pc;
        logic ch;
        logic sr;
    } cause_t;
endpackage

// File: rtl/dbg_regs.sv
module dbg_regs
    import dbg_pkg::*;
#(
    parameter int PC_W = 10,
    parameter int CH_W = 4,
    parameter int DW   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [1:0]        addr_i,
    input  logic [DW-1:0]     wdata_i,
    input  cause_t            stat_i,
    output logic [NUM_EN-1:0] en_o,
    output logic              mode_o,
    output logic [PC_W-1:0]   pcbp_o,
    output logic [CH_W-1:0]   chbp_o,
    output logic [DW-1:0]     rdata_o
);
    typedef struct packed {
        logic [NUM_EN-1:0] en;
        logic              mode;
        logic [PC_W-1:0]   pcbp;
        logic [CH_W-1:0]   chbp;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_i) begin
            case (addr_e'(addr_i))
                A_CTRL: begin
                    r_d.en   = wdata_i[NUM_EN-1:0];
                    r_d.mode = wdata_i[MODE_BIT];
                end
                A_PCBP:  r_d.pcbp = wdata_i[PC_W-1:0];
                A_CHBP:  r_d.chbp = wdata_i[CH_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata_o = '0;
        case (addr_e'(addr_i))
            A_CTRL: begin
                rdata_o[NUM_EN-1:0] = r_q.en;
                rdata_o[MODE_BIT]   = r_q.mode;
            end
            A_PCBP:  rdata_o[PC_W-1:0] = r_q.pcbp;
            A_CHBP:  rdata_o[CH_W-1:0] = r_q.chbp;
            default: rdata_o[3:0]      = stat_i;
        endcase
    end

    assign en_o   = r_q.en;
    assign mode_o = r_q.mode;
    assign pcbp_o = r_q.pcbp;
    assign chbp_o = r_q.chbp;

    logic unused_wdata;
    assign unused_wdata = ^wdata_i;

    AST_STATUS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == A_STAT) |=> $stable(r_q)); // R10
endmodule

// File: rtl/dbg_detect.sv
module dbg_detect
    import dbg_pkg::*;
#(
    parameter int PC_W = 10,
    parameter int CH_W = 4
) (
    input  logic               start_i,
    input  logic               chwr_i,
    input  logic [PC_W-1:0]    pc_i,
    input  logic [CH_W-1:0]    ch_i,
    input  logic [PC_W-1:0]    pcbp_i,
    input  logic [CH_W-1:0]    chbp_i,
    input  logic [NUM_EN-1:0]  en_i,
    input  logic [NUM_SVC-1:0] svc_i,
    output logic               pc_hit_o,
    output logic               ch_hit_o,
    output logic               sr_hit_o
);
    logic [NUM_SVC-1:0] svc_fire;

    for (genvar k = 0; k < NUM_SVC; k++) begin : g_svc
        assign svc_fire[k] = start_i & en_i[EN_SVC0+k] & svc_i[k];
    end

    assign pc_hit_o = start_i & en_i[EN_PC] & (pc_i == pcbp_i);
    assign ch_hit_o = (start_i | chwr_i) & en_i[EN_CH] & (ch_i == chbp_i);
    assign sr_hit_o = |svc_fire;
endmodule

// File: rtl/dbg_status.sv
module dbg_status
    import dbg_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pc_hit_i,
    input  logic   ch_hit_i,
    input  logic   sr_hit_i,
    input  logic   clr_i,
    output cause_t stat_o,
    output logic   brk_o
);
    typedef struct packed {
        cause_t c;
        logic   brk;
    } st_t;

    st_t  st_d, st_q;
    logic any_hit;

    always_comb begin
        any_hit  = pc_hit_i | ch_hit_i | sr_hit_i;
        st_d     = st_q;
        st_d.brk = 1'b0;
        if (clr_i) begin
            st_d.c = '0;
        end else if (!st_q.c.flag && any_hit) begin
            st_d.c.flag = 1'b1;
            st_d.c.pc   = pc_hit_i;
            st_d.c.ch   = ch_hit_i;
            st_d.c.sr   = sr_hit_i;
            st_d.brk    = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_o = st_q.c;
    assign brk_o  = st_q.brk;

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (st_q.c == '0)); // R6
    AST_STICKY_CAUSES: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.c.flag && !clr_i) |=> (st_q.c.flag && $stable(st_q.c))); // R7
    AST_HIT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.c.flag && any_hit && !clr_i) |=> (st_q.c.flag && st_q.brk)); // R5
    AST_BRK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.brk |=> !st_q.brk); // R5
    AST_CAUSE_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.c.pc || st_q.c.ch || st_q.c.sr) |-> st_q.c.flag); // R6
endmodule

// File: rtl/dbg_cond_latch.sv
module dbg_cond_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic chwr_i,
    input  logic mode_i,
    input  logic pin_i,
    input  logic mrec_i,
    input  logic tdet_i,
    output logic pin_o,
    output logic mrec_o,
    output logic tdet_o
);
    typedef struct packed {
        logic pin;
        logic mrec;
        logic tdet;
    } cond_t;

    cond_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (chwr_i) begin
            c_d.pin = pin_i;
            if (mode_i) begin
                c_d.mrec = mrec_i;
                c_d.tdet = tdet_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign pin_o  = c_q.pin;
    assign mrec_o = c_q.mrec;
    assign tdet_o = c_q.tdet;

    AST_MODE0_KEEPS_COND: assert property (@(posedge clk) disable iff (!rst_n)
        (chwr_i && !mode_i) |=> ($stable(c_q.mrec) && $stable(c_q.tdet))); // R9
    AST_NO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !chwr_i |=> $stable(c_q)); // R9
endmodule

// File: rtl/dbg_brk_unit.sv
module dbg_brk_unit
    import dbg_pkg::*;
#(
    parameter int PC_W = 10,
    parameter int CH_W = 4,
    parameter int DW   = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr_i,
    input  logic [1:0]      reg_addr_i,
    input  logic [DW-1:0]   reg_wdata_i,
    output logic [DW-1:0]   reg_rdata_o,
    input  logic [PC_W-1:0] pc_i,
    input  logic [CH_W-1:0] chan_i,
    input  logic            chan_wr_i,
    input  logic            state_start_i,
    input  logic            host_sr_i,
    input  logic            link_sr_i,
    input  logic            mrec_i,
    input  logic            tdet_i,
    input  logic            new_pin_i,
    input  logic            new_mrec_i,
    input  logic            new_tdet_i,
    input  logic            ack_i,
    input  logic            freeze_i,
    output logic            halt_o,
    output logic            brk_o,
    output logic            cond_pin_o,
    output logic            cond_mrec_o,
    output logic            cond_tdet_o
);
    logic [NUM_EN-1:0] en;
    logic              mode;
    logic [PC_W-1:0]   pcbp;
    logic [CH_W-1:0]   chbp;
    cause_t            stat;
    logic              pc_hit, ch_hit, sr_hit;

    dbg_regs #(.PC_W(PC_W), .CH_W(CH_W), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
        .wdata_i(reg_wdata_i), .stat_i(stat), .en_o(en), .mode_o(mode),
        .pcbp_o(pcbp), .chbp_o(chbp), .rdata_o(reg_rdata_o)
    );

    dbg_detect #(.PC_W(PC_W), .CH_W(CH_W)) u_detect (
        .start_i(state_start_i), .chwr_i(chan_wr_i), .pc_i(pc_i), .ch_i(chan_i),
        .pcbp_i(pcbp), .chbp_i(chbp), .en_i(en),
        .svc_i({tdet_i, mrec_i, link_sr_i, host_sr_i}),
        .pc_hit_o(pc_hit), .ch_hit_o(ch_hit), .sr_hit_o(sr_hit)
    );

    dbg_status u_status (
        .clk(clk), .rst_n(rst_n), .pc_hit_i(pc_hit), .ch_hit_i(ch_hit),
        .sr_hit_i(sr_hit), .clr_i(ack_i | freeze_i), .stat_o(stat), .brk_o(brk_o)
    );

    dbg_cond_latch u_cond (
        .clk(clk), .rst_n(rst_n), .chwr_i(chan_wr_i), .mode_i(mode),
        .pin_i(new_pin_i), .mrec_i(new_mrec_i), .tdet_i(new_tdet_i),
        .pin_o(cond_pin_o), .mrec_o(cond_mrec_o), .tdet_o(cond_tdet_o)
    );

    assign halt_o = stat.flag;

    AST_NO_EVAL_NO_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (!state_start_i && !chan_wr_i && !halt_o) |=> !halt_o); // R8
    AST_DISABLED_NO_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0 && !halt_o) |=> !halt_o); // R8
endmodule

// File: tb/tb_dbg_brk_unit.sv
module tb_dbg_brk_unit;
    localparam int PC_W = 10;
    localparam int CH_W = 4;
    localparam int DW   = 16;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic            rst_n;
    logic            reg_wr_i;
    logic [1:0]      reg_addr_i;
    logic [DW-1:0]   reg_wdata_i;
    logic [DW-1:0]   reg_rdata_o;
    logic [PC_W-1:0] pc_i;
    logic [CH_W-1:0] chan_i;
    logic chan_wr_i, state_start_i, host_sr_i, link_sr_i, mrec_i, tdet_i;
    logic new_pin_i, new_mrec_i, new_tdet_i, ack_i, freeze_i;
    logic halt_o, brk_o, cond_pin_o, cond_mrec_o, cond_tdet_o;

    dbg_brk_unit #(.PC_W(PC_W), .CH_W(CH_W), .DW(DW)) dut (.*);

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference state
    logic [5:0]      m_en;
    logic            m_mode;
    logic [PC_W-1:0] m_pcbp;
    logic [CH_W-1:0] m_chbp;
    logic [3:0]      m_stat;
    logic            m_brk;
    logic [2:0]      m_cond;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] exp_read(input logic [1:0] a);
        logic [DW-1:0] r = '0;
        case (a)
            2'd0: begin r[5:0] = m_en; r[8] = m_mode; end
            2'd1: r[PC_W-1:0] = m_pcbp;
            2'd2: r[CH_W-1:0] = m_chbp;
            default: r[3:0] = m_stat;
        endcase
        return r;
    endfunction

    function automatic logic [2:0] exp_hits();
        logic pc_h, ch_h, sr_h;
        pc_h = state_start_i && m_en[0] && (pc_i == m_pcbp);
        ch_h = (state_start_i || chan_wr_i) && m_en[1] && (chan_i == m_chbp);
        sr_h = state_start_i && ((m_en[2] && host_sr_i) || (m_en[3] && link_sr_i) ||
                                 (m_en[4] && mrec_i) || (m_en[5] && tdet_i));
        return {pc_h, ch_h, sr_h};
    endfunction

    task automatic model_edge();
        logic [2:0] h;
        logic       old_mode;
        h = exp_hits();
        old_mode = m_mode;
        m_brk = 1'b0;
        if (ack_i || freeze_i) m_stat = 4'b0;
        else if (!m_stat[3] && (|h)) begin
            m_stat = {1'b1, h};
            m_brk  = 1'b1;
        end
        if (reg_wr_i) begin
            case (reg_addr_i)
                2'd0: begin m_en = reg_wdata_i[5:0]; m_mode = reg_wdata_i[8]; end
                2'd1: m_pcbp = reg_wdata_i[PC_W-1:0];
                2'd2: m_chbp = reg_wdata_i[CH_W-1:0];
                default: ;
            endcase
        end
        if (chan_wr_i) begin
            m_cond[2] = new_pin_i;
            if (old_mode) m_cond[1:0] = {new_mrec_i, new_tdet_i};
        end
    endtask

    task automatic idle();
        reg_wr_i = 0; reg_addr_i = 2'd3; reg_wdata_i = '0;
        pc_i = '0; chan_i = '0; chan_wr_i = 0; state_start_i = 0;
        host_sr_i = 0; link_sr_i = 0; mrec_i = 0; tdet_i = 0;
        new_pin_i = 0; new_mrec_i = 0; new_tdet_i = 0; ack_i = 0; freeze_i = 0;
    endtask

    // one clock with the current inputs, then full comparison at the falling edge
    task automatic step();
        model_edge();
        @(posedge clk);
        @(negedge clk);
        chk("R5 halt", halt_o, m_stat[3]);
        chk("R5 brk", brk_o, m_brk);
        chk("R9 cond", {cond_pin_o, cond_mrec_o, cond_tdet_o}, m_cond);
        chk("R10 read", reg_rdata_o, exp_read(reg_addr_i));
    endtask

    task automatic wreg(input logic [1:0] a, input logic [DW-1:0] d);
        idle(); reg_wr_i = 1; reg_addr_i = a; reg_wdata_i = d;
        step();
        idle();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        idle();
        rst_n = 0;
        m_en = '0; m_mode = 0; m_pcbp = '0; m_chbp = '0;
        m_stat = '0; m_brk = 0; m_cond = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        chk("R1 halt", halt_o, 0);
        chk("R1 brk", brk_o, 0);
        chk("R1 status", reg_rdata_o, 0);
        reg_addr_i = 2'd0; #1;
        chk("R1 ctrl", reg_rdata_o, 0);
        idle();

        // R2 PC source, gating by strobe (R8)
        wreg(2'd1, 16'd5);
        wreg(2'd0, 16'h0001);
        pc_i = 10'd5; step();
        chk("R8 pc no strobe", halt_o, 0);
        pc_i = 10'd5; state_start_i = 1; step(); idle();
        chk("R2 halt", halt_o, 1);
        chk("R2 status", reg_rdata_o, 16'hC);
        chk("R5 brk pulse", brk_o, 1);
        step();
        chk("R5 brk once", brk_o, 0);
        chk("R5 halt held", halt_o, 1);

        // R7 sticky: channel hit while flagged
        wreg(2'd0, 16'h0003);
        state_start_i = 1; pc_i = 10'd5; chan_i = '0; step(); idle();
        chk("R7 status kept", reg_rdata_o, 16'hC);
        chk("R7 no new brk", brk_o, 0);

        // R6 ack clears, and beats a same-cycle hit
        ack_i = 1; step(); idle();
        chk("R6 ack clear", reg_rdata_o, 0);
        ack_i = 1; state_start_i = 1; pc_i = 10'd5; step(); idle();
        chk("R6 clear wins", halt_o, 0);

        // R3 channel source on channel write only
        wreg(2'd2, 16'd3);
        wreg(2'd0, 16'h0002);
        chan_i = 4'd3; chan_wr_i = 1; step(); idle();
        chk("R3 chan write hit", reg_rdata_o, 16'hA);
        freeze_i = 1; step(); idle();
        chk("R6 freeze clear", halt_o, 0);
        chan_i = 4'd3; state_start_i = 1; step(); idle();
        chk("R3 chan start hit", reg_rdata_o, 16'hA);
        freeze_i = 1; step(); idle();

        // R4 service sources with enable and strobe
        wreg(2'd0, 16'h0004);
        link_sr_i = 1; mrec_i = 1; tdet_i = 1; state_start_i = 1; step(); idle();
        chk("R8 disabled svc", halt_o, 0);
        host_sr_i = 1; step(); idle();
        chk("R4 host no strobe", halt_o, 0);
        host_sr_i = 1; state_start_i = 1; step(); idle();
        chk("R4 host hit", reg_rdata_o, 16'h9);
        ack_i = 1; step(); idle();

        // multiple causes in one cycle
        wreg(2'd0, 16'h003F);
        state_start_i = 1; pc_i = 10'd5; chan_i = 4'd3; tdet_i = 1; step(); idle();
        chk("R2 R3 R4 all causes", reg_rdata_o, 16'hF);
        ack_i = 1; step(); idle();

        // R10 status read-only, readback of compare registers
        wreg(2'd3, 16'hFFFF);
        chk("R10 status write ignored", reg_rdata_o, 0);
        chk("R10 no halt from write", halt_o, 0);
        reg_addr_i = 2'd1; #1;
        chk("R10 pc readback", reg_rdata_o, 16'd5);
        idle();

        // R9 capture mode
        wreg(2'd0, 16'h0000);
        chan_wr_i = 1; new_pin_i = 1; new_mrec_i = 1; new_tdet_i = 1; step(); idle();
        chk("R9 mode0", {cond_pin_o, cond_mrec_o, cond_tdet_o}, 3'b100);
        wreg(2'd0, 16'h0100);
        chan_wr_i = 1; new_pin_i = 0; new_mrec_i = 1; new_tdet_i = 1; step(); idle();
        chk("R9 mode1", {cond_pin_o, cond_mrec_o, cond_tdet_o}, 3'b011);

        // constrained random traffic
        for (int i = 0; i < 3000; i++) begin
            idle();
            reg_addr_i    = 2'($urandom_range(0, 3));
            reg_wr_i      = ($urandom_range(0, 15) == 0);
            reg_wdata_i   = DW'($urandom);
            pc_i          = ($urandom_range(0, 1) == 0) ? m_pcbp : PC_W'($urandom);
            chan_i        = ($urandom_range(0, 1) == 0) ? m_chbp : CH_W'($urandom);
            chan_wr_i     = ($urandom_range(0, 3) == 0);
            state_start_i = ($urandom_range(0, 2) == 0);
            host_sr_i     = ($urandom_range(0, 5) == 0);
            link_sr_i     = ($urandom_range(0, 5) == 0);
            mrec_i        = ($urandom_range(0, 5) == 0);
            tdet_i        = ($urandom_range(0, 5) == 0);
            new_pin_i     = 1'($urandom);
            new_mrec_i    = 1'($urandom);
            new_tdet_i    = 1'($urandom);
            ack_i         = ($urandom_range(0, 9) == 0);
            freeze_i      = ($urandom_range(0, 19) == 0);
            step();
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule